// File: doc/BRIEF.md
# Power-Up Timer Reset Sequencer

This block produces the chip-wide internal reset from three sources: a pulse from the power-on detector, the synchronised external active-low reset pin, and a power-up timer. The timer is a small counter that advances on enable ticks from the slow internal RC oscillator, which are already in the system clock domain. It begins counting only once the power-on pulse has gone away. While it counts, internal reset stays asserted. It cannot be disabled.

Internal reset is released only when the timer has expired, no power-on pulse is present and the external pin is high. The timer is started only by the power-on pulse, never by the pin. If the pin is held low longer than the timeout, the timer expires underneath it, and raising the pin then releases the device in the same cycle. This lets several devices be released together from one pin. A done flag reports that the timeout has elapsed.

Top module: `pwrt_reset_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the counter and `tmo_done_o` are cleared. `int_rst_o` is therefore high, whatever `tick_i` does.
- R2: While `por_i` is high, `int_rst_o` is high in that same cycle. The next edge clears the counter and `tmo_done_o`, and a tick in that cycle is not counted.
- R3: With `por_i` low, each cycle with `tick_i` high advances the count by one. `tmo_done_o` goes high at the edge that takes the 2**CNT_W-th tick after the power-on pulse cleared (the 32nd with the default CNT_W = 5).
- R4: A cycle with `tick_i` low leaves the count unchanged, so gaps between ticks only stretch the timeout.
- R5: Once set, `tmo_done_o` stays high through further ticks and through any activity on the pin. It clears only on `por_i` or `rst_n`.
- R6: `int_rst_o` is high in every cycle in which `tmo_done_o` is low.
- R7: `int_rst_o` is high in every cycle in which `ext_rst_n_i` is low.
- R8: When `tmo_done_o` is high and `por_i` is low, `int_rst_o` follows the pin combinationally. It drops in the same cycle that `ext_rst_n_i` goes high, with no added delay.
- R9: A low level on `ext_rst_n_i` neither clears nor pauses the timer. Ticks taken while the pin is low count toward the timeout.
- R10: A power-on pulse arriving mid-count or after expiry restarts the full timeout from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| tick_i | input | 1 | One-cycle enable pulse per internal RC oscillator period |
| por_i | input | 1 | Power-on reset pulse, active high |
| ext_rst_n_i | input | 1 | Synchronised external reset pin, active low |
| int_rst_o | output | 1 | Internal reset, active high |
| tmo_done_o | output | 1 | Power-up timeout has elapsed |

## Verification
The main sweep raises the power-on pulse and then applies every tick count from 0 to 36 with the pin high. This separates an off-by-one terminal count from a correct one: the 31-tick and 32-tick cases must differ. The same sweep is repeated with a tick only every other cycle, which shows that idle cycles do not advance the count. Further patterns cover the following:
- The pin held low across the whole timeout, which tells a timer restarted by the pin apart from one started only by the power-on pulse, and checks that release comes in the same cycle the pin rises.
- A power-on pulse in mid-count, which must restart the full timeout.
- A power-on pulse after expiry, which must also restart the full timeout.

// File: rtl/pwrt_pkg.sv
// Package: shared sizing for the power-up timer reset sequencer.
// Assumes the counter width is small (a handful of bits).
package pwrt_pkg;
    parameter int unsigned PWRT_CNT_W = 5;
endpackage

// File: rtl/pwrt_counter.sv
// Module: power-up timer counter.
// Counts oscillator enable ticks after the power-on pulse clears and
// raises a sticky done flag on the tick taken at the terminal count.
// Assumes tick_i is a single-cycle enable in the clk domain.
module pwrt_counter #(
    parameter int unsigned CNT_W = pwrt_pkg::PWRT_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             por_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    // Advance the count on each tick; hold at terminal count and flag done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (por_i) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (tick_i && !done_q) begin
            if (cnt_q == TERM) begin
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign done_o = done_q;

    p_por_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> (cnt_q == '0) && !done_q);

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !por_i && !done_q && cnt_q != TERM) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    p_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !por_i) |=> $stable(cnt_q) && $stable(done_q));

    p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !por_i) |=> done_q);

    p_done_at_term_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> cnt_q == TERM);
endmodule

// File: rtl/pwrt_rst_merge.sv
// Module: internal reset merge.
// Asserts internal reset while a power-on pulse is present, while the
// timer has not expired, or while the external pin is low.
// Assumes all inputs are already in the clk domain.
module pwrt_rst_merge (
    input  logic por_i,
    input  logic done_i,
    input  logic ext_rst_n_i,
    output logic int_rst_o
);
    // Combine the three reset sources; no added delay on pin release.
    always_comb begin
        int_rst_o = por_i | ~done_i | ~ext_rst_n_i;
    end
endmodule

// File: rtl/pwrt_reset_seq.sv
// Module: power-up timer reset sequencer (top).
// Holds internal reset through a power-on pulse and a following
// 2**CNT_W-tick timeout, and while the external pin is low.
// Assumes tick_i, por_i and ext_rst_n_i are synchronous to clk.
module pwrt_reset_seq #(
    parameter int unsigned CNT_W = pwrt_pkg::PWRT_CNT_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic por_i,
    input  logic ext_rst_n_i,
    output logic int_rst_o,
    output logic tmo_done_o
);
    logic [CNT_W-1:0] cnt;
    logic             done;

    pwrt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .por_i  (por_i),
        .cnt_o  (cnt),
        .done_o (done)
    );

    pwrt_rst_merge u_merge (
        .por_i       (por_i),
        .done_i      (done),
        .ext_rst_n_i (ext_rst_n_i),
        .int_rst_o   (int_rst_o)
    );

    assign tmo_done_o = done;

    p_hold_until_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tmo_done_o |-> int_rst_o);

    p_pin_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rst_n_i |-> int_rst_o);

    p_pin_keeps_timer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rst_n_i && !por_i && tmo_done_o) |=> tmo_done_o);

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_done_o && !por_i && ext_rst_n_i) |-> !int_rst_o);
endmodule

// File: tb/test_pwrt_reset_seq.sv
// Bench: sweeps tick counts after a power-on pulse and checks outputs
// against a bench-side arithmetic model of the timeout.
module test_pwrt_reset_seq;
    localparam int W    = 5;
    localparam int FULL = 2 ** W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic por = 1'b0;
    logic pin = 1'b1;
    logic int_rst;
    logic done;

    int vectors = 0;
    int errors  = 0;
    int m_ticks = 0;
    bit m_done  = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pwrt_reset_seq #(.CNT_W(W)) i_pwrt_reset_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .por_i       (por),
        .ext_rst_n_i (pin),
        .int_rst_o   (int_rst),
        .tmo_done_o  (done)
    );

    // Compare one output against its expected value.
    task automatic chk(input string req, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus, check outputs mid-cycle, advance the model.
    task automatic apply(input logic t, input logic p, input logic e, input string req);
        @(negedge clk);
        tick = t; por = p; pin = e;
        #1;
        chk(req, "tmo_done_o", done, m_done);
        chk(req, "int_rst_o", int_rst, p | ~m_done | ~e);
        @(posedge clk);
        if (!rst_n || p) begin
            m_ticks = 0; m_done = 1'b0;
        end else if (t && !m_done) begin
            m_ticks++;
            if (m_ticks >= FULL) m_done = 1'b1;
        end
    endtask

    initial begin
        // R1: reset holds everything cleared even with ticks present.
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) apply(1'b1, 1'b0, 1'b1, "R1");
        rst_n = 1'b1;

        // R3 / R6: full sweep of tick counts after a power-on pulse.
        for (int n = 0; n <= FULL + 4; n++) begin
            apply(1'b0, 1'b1, 1'b1, "R2");
            for (int k = 0; k < n; k++) apply(1'b1, 1'b0, 1'b1, "R6");
            apply(1'b0, 1'b0, 1'b1, "R3");
            chk("R3", "done after sweep", done, logic'(n >= FULL));
        end

        // R4: ticks every other cycle, idle cycles must not count.
        for (int n = FULL - 2; n <= FULL + 1; n++) begin
            apply(1'b0, 1'b1, 1'b1, "R2");
            for (int k = 0; k < n; k++) begin
                apply(1'b1, 1'b0, 1'b1, "R4");
                apply(1'b0, 1'b0, 1'b1, "R4");
            end
            chk("R4", "done with gaps", done, logic'(n >= FULL));
        end

        // R2: ticks during the power-on pulse are ignored.
        apply(1'b1, 1'b1, 1'b1, "R2");
        apply(1'b1, 1'b1, 1'b1, "R2");
        for (int k = 0; k < FULL - 1; k++) apply(1'b1, 1'b0, 1'b1, "R2");
        chk("R2", "done one tick short", done, 1'b0);
        apply(1'b1, 1'b0, 1'b1, "R3");

        // R5: done stays through extra ticks and pin activity.
        for (int k = 0; k < 6; k++) apply(1'b1, 1'b0, k[0], "R5");
        chk("R5", "done sticky", done, 1'b1);

        // R7 / R8: pin low holds reset; release in the same cycle it rises.
        apply(1'b0, 1'b0, 1'b0, "R7");
        apply(1'b0, 1'b0, 1'b0, "R7");
        apply(1'b0, 1'b0, 1'b1, "R8");
        chk("R8", "immediate release", int_rst, 1'b0);

        // R9: pin low across the whole timeout; ticks still count.
        apply(1'b0, 1'b1, 1'b0, "R2");
        for (int k = 0; k < FULL + 3; k++) apply(1'b1, 1'b0, 1'b0, "R9");
        chk("R9", "expired under pin", done, 1'b1);
        apply(1'b0, 1'b0, 1'b1, "R9");
        chk("R9", "release on pin rise", int_rst, 1'b0);

        // R10: power-on pulse mid-count restarts the full timeout.
        apply(1'b0, 1'b1, 1'b1, "R10");
        for (int k = 0; k < 20; k++) apply(1'b1, 1'b0, 1'b1, "R10");
        apply(1'b0, 1'b1, 1'b1, "R10");
        for (int k = 0; k < FULL - 1; k++) apply(1'b1, 1'b0, 1'b1, "R10");
        chk("R10", "restart mid-count", done, 1'b0);
        apply(1'b1, 1'b0, 1'b1, "R10");
        apply(1'b0, 1'b0, 1'b1, "R10");
        chk("R10", "restart completes", done, 1'b1);

        // R10: power-on pulse after expiry restarts too.
        apply(1'b0, 1'b1, 1'b1, "R10");
        apply(1'b0, 1'b0, 1'b1, "R10");
        chk("R10", "cleared after expiry", done, 1'b0);
        chk("R10", "reset after expiry", int_rst, 1'b1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule